// File: doc/BRIEF.md
# Two-Channel PWM Output Shaper

This block sits between a PWM counter/comparator and the two output pins of a channel pair. It takes one raw waveform and turns it into two pin levels. In independent mode both channels carry the raw waveform. In complementary mode the second channel carries the inverse of the first, and each output's rising edge is held back by a programmable dead time. A high phase that is too short to outlast the dead time never reaches the pin.

After the dead-time stage, each channel passes through a fixed chain of stages. First an optional mask forces the channel to a programmed level. Then, while the brake input is active, a per-channel brake action takes over the channel. Next comes a per-channel polarity flip. Last, a per-channel output enable drives a disabled pin to 0. All configuration arrives on plain input ports.

The raw waveform reaches the pins through two registers. Mask and brake settings reach the pins through one register. Polarity and enable settings act on the pins at once, with no register.

Top module: `pwm_pair_out`

## Requirements
- R1: After reset, with no inversion and both outputs enabled, both pins are low. The held brake state of each channel clears to 0.
- R2: In independent mode (`comp_mode`=0), with no mask or brake, both pins follow `raw_pwm` two clock cycles later.
- R3: In complementary mode (`comp_mode`=1) with a dead time of 0, `ch_out[0]` follows `raw_pwm` and `ch_out[1]` follows its inverse, both two cycles later.
- R4: In complementary mode with dead time D, each output's rising edge is delayed by D extra cycles. Its falling edge is not delayed.
- R5: In complementary mode, a high phase of D cycles or fewer on a channel's waveform produces no high level on that pin. A high phase of D+1 cycles produces a high level lasting exactly one cycle.
- R6: The dead-time value has no effect in independent mode.
- R7: When mask bit c is set, channel c drives `mask_lvl[c]` one cycle later and ignores the PWM waveform. Bit 0 of every per-channel field belongs to CH0 and bit 1 to CH1.
- R8: While `brake_act` is 1, the brake action overrides the mask. Brake code 2 drives low and code 3 drives high. The code for CH0 is `brake_code[1:0]` and the code for CH1 is `brake_code[3:2]`.
- R9: While `brake_act` is 1, brake code 1 holds the channel's previous pre-polarity level. Brake code 0 inverts that level every cycle.
- R10: Inversion bit c flips pin c after the brake stage, in the same cycle the bit changes.
- R11: A channel whose output-enable bit is 0 drives 0, whatever its inversion bit is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_pwm | input | 1 | Raw waveform from the comparator |
| comp_mode | input | 1 | 1 = complementary pair, 0 = independent |
| dead_cnt | input | 12 | Dead time in clock cycles (complementary mode only) |
| mask_en | input | 2 | Per-channel mask enable |
| mask_lvl | input | 2 | Per-channel forced level while masked |
| brake_act | input | 1 | Brake condition active |
| brake_code | input | 4 | Per-channel brake action, 2 bits per channel |
| inv_mask | input | 2 | Per-channel polarity inversion |
| out_en | input | 2 | Per-channel output enable |
| ch_out | output | 2 | Pin levels, bit 0 = CH0, bit 1 = CH1 |

## Verification
The mask and the brake can both claim a channel in the same cycle. The brake must win. The bench sets both masks to a high level and then raises the brake with low on CH0 and high on CH1. It then expects exactly that split at the pins one cycle later, not the mask level. A second overlap pairs the brake hold and toggle actions with a moving raw waveform, to show that the waveform is ignored. The polarity and enable stages are then changed on top of a braked state, and the bench checks that they take effect without a clock edge.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
   localparam int unsigned PAIR_CH = 2;
   localparam int unsigned BRK_W   = 2;

   typedef enum logic [BRK_W-1:0] {
      BRK_TOGGLE = 2'd0,
      BRK_HOLD   = 2'd1,
      BRK_LOW    = 2'd2,
      BRK_HIGH   = 2'd3
   } brk_act_e;
endpackage

// File: rtl/pwm_dead_band.sv
module pwm_dead_band #(
   parameter int unsigned DT_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            comp_mode,
   input  logic [DT_W-1:0] dead_cnt,
   input  logic            wave_in,
   output logic            wave_out
);
   logic [DT_W-1:0] run_q;
   logic            lvl_q;

   // Rising edges wait until the input has been high for dead_cnt cycles;
   // falling edges pass at once.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         lvl_q <= 1'b0;
      end else if (!comp_mode) begin
         run_q <= '0;
         lvl_q <= wave_in;
      end else if (!wave_in) begin
         run_q <= '0;
         lvl_q <= 1'b0;
      end else if (run_q >= dead_cnt) begin
         lvl_q <= 1'b1;
      end else begin
         run_q <= run_q + 1'b1;
         lvl_q <= 1'b0;
      end
   end

   assign wave_out = lvl_q;
endmodule

// File: rtl/pwm_chan_shaper.sv
module pwm_chan_shaper
   import pwm_pair_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     dt_lvl,
   input  logic     mask_on,
   input  logic     mask_val,
   input  logic     brake_on,
   input  brk_act_e brake_sel,
   input  logic     inv_on,
   input  logic     oen,
   output logic     pin
);
   logic held_q;
   logic masked;
   logic picked;

   always_comb begin
      masked = mask_on ? mask_val : dt_lvl;
      picked = masked;
      if (brake_on) begin
         unique case (brake_sel)
            BRK_TOGGLE: picked = ~held_q;
            BRK_HOLD:   picked = held_q;
            BRK_LOW:    picked = 1'b0;
            BRK_HIGH:   picked = 1'b1;
            default:    picked = held_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held_q <= 1'b0;
      else        held_q <= picked;
   end

   assign pin = oen & (held_q ^ inv_on);
endmodule

// File: rtl/pwm_pair_out.sv
module pwm_pair_out
   import pwm_pair_pkg::*;
#(
   parameter int unsigned DT_W = 12,
   parameter int unsigned CH_N = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  raw_pwm,
   input  logic                  comp_mode,
   input  logic [DT_W-1:0]       dead_cnt,
   input  logic [CH_N-1:0]       mask_en,
   input  logic [CH_N-1:0]       mask_lvl,
   input  logic                  brake_act,
   input  logic [CH_N*BRK_W-1:0] brake_code,
   input  logic [CH_N-1:0]       inv_mask,
   input  logic [CH_N-1:0]       out_en,
   output logic [CH_N-1:0]       ch_out
);
   localparam int unsigned CODE_W = CH_N * BRK_W;

   if (CH_N != PAIR_CH) begin : g_bad_ch
      $error("pwm_pair_out: CH_N must be 2");
   end
   if (DT_W < 1 || DT_W > 16) begin : g_bad_dt
      $error("pwm_pair_out: DT_W out of range");
   end
   if (CODE_W != 4) begin : g_bad_code
      $error("pwm_pair_out: brake code width mismatch");
   end

   logic [CH_N-1:0] split_w;
   logic [CH_N-1:0] dt_w;

   // Complementary split: CH0 always carries the raw wave.
   assign split_w[0] = raw_pwm;
   assign split_w[1] = comp_mode ? ~raw_pwm : raw_pwm;

   for (genvar c = 0; c < CH_N; c++) begin : g_ch
      pwm_dead_band #(.DT_W(DT_W)) u_db (
         .clk       (clk),
         .rst_n     (rst_n),
         .comp_mode (comp_mode),
         .dead_cnt  (dead_cnt),
         .wave_in   (split_w[c]),
         .wave_out  (dt_w[c])
      );

      pwm_chan_shaper u_sh (
         .clk       (clk),
         .rst_n     (rst_n),
         .dt_lvl    (dt_w[c]),
         .mask_on   (mask_en[c]),
         .mask_val  (mask_lvl[c]),
         .brake_on  (brake_act),
         .brake_sel (brk_act_e'(brake_code[c*BRK_W +: BRK_W])),
         .inv_on    (inv_mask[c]),
         .oen       (out_en[c]),
         .pin       (ch_out[c])
      );
   end
endmodule

// File: rtl/pwm_pair_out_chk.sv
module pwm_pair_out_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       comp_mode,
   input logic [1:0] mask_en,
   input logic [1:0] mask_lvl,
   input logic       brake_act,
   input logic [3:0] brake_code,
   input logic [1:0] inv_mask,
   input logic [1:0] out_en,
   input logic [1:0] ch_out
);
   logic [1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            age_q <= 2'd0;
      else if (age_q != 2'd3) age_q <= age_q + 2'd1;
   end

   // R3
   comp_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd3 && comp_mode && $past(comp_mode) && $past(comp_mode, 2) &&
       !$past(brake_act) && $past(mask_en) == 2'b00 &&
       inv_mask == 2'b00 && out_en == 2'b11) |-> !(ch_out[0] && ch_out[1]));

   // R2
   indep_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd3 && !$past(comp_mode) && !$past(comp_mode, 2) &&
       !$past(brake_act) && $past(mask_en) == 2'b00 &&
       inv_mask == 2'b00 && out_en == 2'b11) |-> (ch_out[0] == ch_out[1]));

   // R7
   mask_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q != 2'd0 && $past(mask_en[0]) && !$past(brake_act) &&
       out_en[0] && !inv_mask[0]) |-> (ch_out[0] == $past(mask_lvl[0])));

   // R8
   brake_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q != 2'd0 && $past(brake_act) && $past(brake_code[1:0]) == 2'd2 &&
       out_en[0] && !inv_mask[0]) |-> !ch_out[0]);

   // R9
   brake_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q != 2'd0 && $past(brake_act) && $past(brake_code[3:2]) == 2'd0 &&
       $stable(out_en[1]) && $stable(inv_mask[1]) && out_en[1])
      |-> (ch_out[1] != $past(ch_out[1])));
endmodule

bind pwm_pair_out pwm_pair_out_chk u_chk (.*);

// File: tb/pwm_pair_out_bench.sv
module pwm_pair_out_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        raw_pwm = 1'b0;
   logic        comp_mode = 1'b0;
   logic [11:0] dead_cnt = '0;
   logic [1:0]  mask_en = '0;
   logic [1:0]  mask_lvl = '0;
   logic        brake_act = 1'b0;
   logic [3:0]  brake_code = '0;
   logic [1:0]  inv_mask = '0;
   logic [1:0]  out_en = 2'b11;
   logic [1:0]  ch_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pwm_pair_out u_pwm_pair_out (.*);

   task automatic tick(int n = 1);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic t_reset();
      tick(3);
      rst_n = 1'b1;
      tick(1);
      chk("R1", int'(ch_out), 0);
   endtask

   task automatic t_indep();
      raw_pwm = 1'b1;
      tick(1); chk("R2", int'(ch_out), 0);
      tick(1); chk("R2", int'(ch_out), 3);
      raw_pwm = 1'b0;
      tick(2); chk("R2", int'(ch_out), 0);
   endtask

   task automatic t_comp();
      comp_mode = 1'b1; dead_cnt = 12'd0; raw_pwm = 1'b1;
      tick(2); chk("R3", int'(ch_out), 1);
      raw_pwm = 1'b0;
      tick(2); chk("R3", int'(ch_out), 2);
   endtask

   task automatic t_dead();
      dead_cnt = 12'd3; raw_pwm = 1'b0;
      tick(6); chk("R4", int'(ch_out), 2);
      raw_pwm = 1'b1;
      tick(2); chk("R4", int'(ch_out), 0);
      tick(2); chk("R4", int'(ch_out), 0);
      tick(1); chk("R4", int'(ch_out), 1);
      raw_pwm = 1'b0;
      tick(2); chk("R4", int'(ch_out), 0);
      tick(2); chk("R4", int'(ch_out), 0);
      tick(1); chk("R4", int'(ch_out), 2);
   endtask

   task automatic t_short(int len, int exp_hi);
      int hi = 0;
      raw_pwm = 1'b1;
      for (int i = 0; i < len + 10; i++) begin
         if (i == len) raw_pwm = 1'b0;
         tick(1);
         hi += int'(ch_out[0]);
      end
      chk("R5", hi, exp_hi);
   endtask

   task automatic t_indep_dead();
      comp_mode = 1'b0; dead_cnt = 12'd3; raw_pwm = 1'b0;
      tick(3);
      raw_pwm = 1'b1;
      tick(2); chk("R6", int'(ch_out), 3);
   endtask

   task automatic t_mask();
      mask_en = 2'b01; mask_lvl = 2'b00;
      tick(1); chk("R7", int'(ch_out), 2);
      mask_en = 2'b11; mask_lvl = 2'b11; raw_pwm = 1'b0;
      tick(1); chk("R7", int'(ch_out), 3);
      tick(2); chk("R7", int'(ch_out), 3);
   endtask

   task automatic t_brake_over_mask();
      brake_act = 1'b1; brake_code = {2'd3, 2'd2};
      tick(1); chk("R8", int'(ch_out), 2);
      mask_en = 2'b00;
   endtask

   task automatic t_hold_toggle();
      brake_code = {2'd2, 2'd3};
      tick(1); chk("R9", int'(ch_out), 1);
      brake_code = {2'd0, 2'd1}; raw_pwm = 1'b1;
      tick(1); chk("R9", int'(ch_out), 3);
      raw_pwm = 1'b0;
      tick(1); chk("R9", int'(ch_out), 1);
      tick(1); chk("R9", int'(ch_out), 3);
      brake_code = {2'd2, 2'd3};
      tick(1); chk("R9", int'(ch_out), 1);
   endtask

   task automatic t_polarity();
      inv_mask = 2'b11; #1;
      chk("R10", int'(ch_out), 2);
      inv_mask = 2'b01; #1;
      chk("R10", int'(ch_out), 0);
   endtask

   task automatic t_enable();
      inv_mask = 2'b11; out_en = 2'b00; #1;
      chk("R11", int'(ch_out), 0);
      out_en = 2'b10; #1;
      chk("R11", int'(ch_out), 2);
      out_en = 2'b11; inv_mask = 2'b00; brake_act = 1'b0;
      tick(1);
   endtask

   initial begin
      t_reset();
      t_indep();
      t_comp();
      t_dead();
      t_short(3, 0);
      t_short(4, 1);
      t_indep_dead();
      t_mask();
      t_brake_over_mask();
      t_hold_toggle();
      t_polarity();
      t_enable();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule